// File: doc/BRIEF.md
# Frame Memory Rectangle Transfer Engine

This block moves a rectangle of 16-bit pixels between a 32-bit data port and a frame memory that is 1024 pixels wide and 512 rows tall. A header gives the rectangle's corner, its size and the direction of the transfer. In the write direction the block accepts 32-bit words. It splits each word into two pixels and stores them one per cycle through a single-ported synchronous memory interface. In the read direction it fetches pixels, pairs them into 32-bit words, and offers each word on a read-data register. The first word is loaded there before anyone asks for it.

The walk through the rectangle is row-major. Columns wrap at the right edge of the frame and rows wrap at the bottom. Either side may leave the data port idle at any point, including in the middle of a row. The position inside the row is kept, so the next word continues where the last one stopped. An image-ready flag tells the consumer that a read is in progress. A new header always takes over from the transfer in progress.

Top module: `vram_rect_xfer`

## Requirements
- R1: After a synchronous reset, wd_ready, rd_avail, img_ready, mem_we and mem_re are all 0 and rd_data is 0.
- R2: The corner column is hdr_pos[9:0] and the corner row is hdr_pos[24:16]. The first pixel is at memory address row*1024 + column.
- R3: The width is hdr_size[9:0] and the height is hdr_size[24:16]. A zero field means 1024 columns or 512 rows respectively.
- R4: Pixels are visited row by row, left to right. Within a row the column is (corner column + offset) mod 1024.
- R5: The row advances by one at the end of each rectangle row, modulo 512.
- R6: Each accepted write word yields writes of bits 15:0 first and then bits 31:16, on the two cycles that follow acceptance. wd_ready is low while those writes are pending.
- R7: When only one pixel of the rectangle remains, the next write word stores only bits 15:0. A read word then carries that pixel in bits 15:0 and zero in bits 31:16.
- R8: Idle cycles on the data port, in the middle of a row or at its end, do not disturb the walk. The next word continues at the following pixel.
- R9: A read header sets img_ready on the next cycle. rd_avail then rises with the first two pixels already in rd_data. img_ready clears after the word that holds the last pixel is taken with rd_take.
- R10: Once every pixel has been transferred, wd_ready stays 0, rd_avail stays 0 and no further memory access is made.
- R11: A header that arrives while a transfer is active drops any pixel not yet issued, as well as a read word not yet taken. The new rectangle starts from its corner.
- R12: A memory read returns data on mem_rdata one cycle after mem_re. mem_we and mem_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Start a transfer with the header below (one cycle) |
| hdr_read | input | 1 | 1 for memory-to-port, 0 for port-to-memory |
| hdr_pos | input | 32 | Corner: column in 9:0, row in 24:16 |
| hdr_size | input | 32 | Extent: width in 9:0, height in 24:16, zero means maximum |
| wd_valid | input | 1 | Write word offered |
| wd_data | input | 32 | Write word, first pixel in bits 15:0 |
| wd_ready | output | 1 | Write word accepted at the edge when valid |
| rd_take | input | 1 | Consume the current read word |
| rd_data | output | 32 | Read word, first pixel in bits 15:0 |
| rd_avail | output | 1 | rd_data holds an untaken word |
| img_ready | output | 1 | Read transfer in progress |
| mem_addr | output | 19 | Pixel address row*1024 + column |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel to write |
| mem_re | output | 1 | Pixel read strobe |
| mem_rdata | input | 16 | Read pixel, valid one cycle after mem_re |

## Verification
The assertions rely on a few assumptions about the inputs. The memory returns each read pixel exactly one cycle after the strobe. A write word stays offered until the block accepts it. rd_take is only acted on while rd_avail is high. The bench's memory model answers with that fixed one-cycle latency. Its tasks hold wd_valid steady until wd_ready is seen and raise rd_take only after rd_avail. Headers are issued on a falling edge, so they meet the block in a known state, including the abort cases where a word or a fetch is still in flight.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
    localparam int XW     = 10;          // column bits: 1024 wide
    localparam int YW     = 9;           // row bits: 512 tall
    localparam int AW     = XW + YW;     // pixel address bits
    localparam int PW     = 16;          // pixel bits
    localparam int DW     = 2 * PW;      // data word bits
    localparam int ROW_LSB = 16;         // row / height field position

    typedef logic [XW-1:0] col_t;
    typedef logic [XW:0]   wid_t;
    typedef logic [YW-1:0] row_t;
    typedef logic [YW:0]   hgt_t;
    typedef logic [AW-1:0] addr_t;
    typedef logic [PW-1:0] pix_t;
    typedef logic [DW-1:0] word_t;

    typedef struct packed {
        col_t x;
        row_t y;
        wid_t w;
        hgt_t h;
    } rect_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LO,
        RD_HI
    } rd_state_e;

    // zero-sized fields stand for the full frame extent
    function automatic rect_t decode_rect(input word_t pos, input word_t size);
        rect_t r;
        r.x = pos[XW-1:0];
        r.y = pos[ROW_LSB +: YW];
        r.w = (size[XW-1:0] == '0) ? wid_t'(1 << XW) : {1'b0, size[XW-1:0]};
        r.h = (size[ROW_LSB +: YW] == '0) ? hgt_t'(1 << YW) : {1'b0, size[ROW_LSB +: YW]};
        return r;
    endfunction

    function automatic addr_t pix_addr(input row_t y, input col_t x);
        return {y, x};
    endfunction
endpackage

// File: rtl/vxfer_walker.sv
module vxfer_walker
    import vxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  rect_t rect,
    input  logic  step,
    output addr_t addr,
    output logic  last,
    output logic  done
);
    col_t x0;
    col_t col;
    wid_t width;
    row_t row;
    hgt_t rows_left;
    logic row_end;

    assign row_end = (wid_t'(col) + wid_t'(1)) == width;

    always_ff @(posedge clk) begin
        if (rst) begin
            x0        <= '0;
            col       <= '0;
            width     <= wid_t'(1);
            row       <= '0;
            rows_left <= '0;
        end else if (load) begin
            x0        <= rect.x;
            col       <= '0;
            width     <= rect.w;
            row       <= rect.y;
            rows_left <= rect.h;
        end else if (step && rows_left != '0) begin
            if (row_end) begin
                col       <= '0;
                row       <= row + 1'b1;
                rows_left <= rows_left - 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

    assign addr = pix_addr(row, col_t'(x0 + col));
    assign done = (rows_left == '0);
    assign last = (rows_left == hgt_t'(1)) && row_end;

    // R4: the offset inside a row never reaches the width
    a_r4_col_in_range: assert property (@(posedge clk) disable iff (rst)
        !done |-> (wid_t'(col) < width));

    // R10: nothing asks for another pixel once the rectangle is exhausted
    a_r10_no_step_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !step);

    // R5: finishing a row returns the offset to the left edge
    a_r5_row_restart: assert property (@(posedge clk) disable iff (rst)
        (step && row_end && !load && !done) |=> (col == '0));
endmodule

// File: rtl/vxfer_wr.sv
module vxfer_wr
    import vxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  active,
    input  logic  last,
    input  logic  in_valid,
    input  word_t in_data,
    output logic  in_ready,
    output logic  px_we,
    output pix_t  px_data,
    output logic  px_step
);
    word_t      hold;
    logic [1:0] pend;
    logic       upper;

    assign in_ready = active && (pend == 2'd0);
    assign px_we    = (pend != 2'd0);
    assign px_step  = px_we;
    assign px_data  = upper ? hold[DW-1:PW] : hold[PW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            pend  <= 2'd0;
            upper <= 1'b0;
        end else if (abort) begin
            pend  <= 2'd0;
            upper <= 1'b0;
        end else if (in_valid && in_ready) begin
            hold  <= in_data;
            pend  <= last ? 2'd1 : 2'd2;
            upper <= 1'b0;
        end else if (pend != 2'd0) begin
            pend  <= pend - 2'd1;
            upper <= 1'b1;
        end
    end

    // R6: an accepted word is written out starting on the next cycle
    a_r6_word_gives_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !abort) |=> px_we);

    // R6: no new word while a pixel of the previous one is still pending
    a_r6_ready_no_write: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !px_we);
endmodule

// File: rtl/vxfer_rd.sv
module vxfer_rd
    import vxfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  abort,
    input  logic  active,
    input  logic  last,
    input  logic  take,
    input  pix_t  mem_data,
    output logic  px_re,
    output logic  px_step,
    output word_t out_word,
    output logic  out_avail
);
    rd_state_e st;
    logic      single;
    pix_t      lo;

    always_comb begin
        px_re = 1'b0;
        case (st)
            RD_IDLE: px_re = active && !out_avail;
            RD_LO:   px_re = !single;
            default: px_re = 1'b0;
        endcase
    end

    assign px_step = px_re;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RD_IDLE;
            single    <= 1'b0;
            lo        <= '0;
            out_word  <= '0;
            out_avail <= 1'b0;
        end else if (abort) begin
            st        <= RD_IDLE;
            single    <= 1'b0;
            out_avail <= 1'b0;
        end else begin
            if (take && out_avail)
                out_avail <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (px_re) begin
                        st     <= RD_LO;
                        single <= last;
                    end
                end
                RD_LO: begin
                    if (single) begin
                        out_word  <= {{PW{1'b0}}, mem_data};
                        out_avail <= 1'b1;
                        st        <= RD_IDLE;
                    end else begin
                        lo <= mem_data;
                        st <= RD_HI;
                    end
                end
                default: begin
                    out_word  <= {mem_data, lo};
                    out_avail <= 1'b1;
                    st        <= RD_IDLE;
                end
            endcase
        end
    end

    // R9: an offered word stays put until it is taken or replaced by a header
    a_r9_word_held: assert property (@(posedge clk) disable iff (rst)
        (out_avail && !take && !abort) |=> (out_avail && $stable(out_word)));

    // R12: no fetch is issued while a finished word waits
    a_r12_no_fetch_while_full: assert property (@(posedge clk) disable iff (rst)
        out_avail |-> !px_re);
endmodule

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer
    import vxfer_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hdr_valid,
    input  logic        hdr_read,
    input  logic [31:0] hdr_pos,
    input  logic [31:0] hdr_size,
    input  logic        wd_valid,
    input  logic [31:0] wd_data,
    output logic        wd_ready,
    input  logic        rd_take,
    output logic [31:0] rd_data,
    output logic        rd_avail,
    output logic        img_ready,
    output logic [18:0] mem_addr,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    output logic        mem_re,
    input  logic [15:0] mem_rdata
);
    logic  dir_rd;
    logic  flag;
    rect_t rect;
    addr_t w_addr;
    logic  w_last;
    logic  w_done;
    logic  wr_step;
    logic  rd_step;
    logic  step;
    logic  wr_we;
    pix_t  wr_pix;
    logic  rd_re;
    word_t rd_word;
    logic  rd_full;

    assign rect = decode_rect(hdr_pos, hdr_size);
    assign step = wr_step | rd_step;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_rd <= 1'b0;
            flag   <= 1'b0;
        end else if (hdr_valid) begin
            dir_rd <= hdr_read;
            flag   <= hdr_read;
        end else if (rd_take && rd_full && w_done) begin
            flag <= 1'b0;
        end
    end

    vxfer_walker u_walker (
        .clk  (clk),
        .rst  (rst),
        .load (hdr_valid),
        .rect (rect),
        .step (step),
        .addr (w_addr),
        .last (w_last),
        .done (w_done)
    );

    vxfer_wr u_wr (
        .clk      (clk),
        .rst      (rst),
        .abort    (hdr_valid),
        .active   (!dir_rd && !w_done),
        .last     (w_last),
        .in_valid (wd_valid),
        .in_data  (wd_data),
        .in_ready (wd_ready),
        .px_we    (wr_we),
        .px_data  (wr_pix),
        .px_step  (wr_step)
    );

    vxfer_rd u_rd (
        .clk       (clk),
        .rst       (rst),
        .abort     (hdr_valid),
        .active    (dir_rd && !w_done),
        .last      (w_last),
        .take      (rd_take),
        .mem_data  (mem_rdata),
        .px_re     (rd_re),
        .px_step   (rd_step),
        .out_word  (rd_word),
        .out_avail (rd_full)
    );

    assign mem_addr  = w_addr;
    assign mem_we    = wr_we;
    assign mem_wdata = wr_pix;
    assign mem_re    = rd_re;
    assign rd_data   = rd_word;
    assign rd_avail  = rd_full;
    assign img_ready = flag;

    // R12: one memory operation per cycle
    a_r12_we_re_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R9: a word is only offered during a read transfer
    a_r9_avail_implies_flag: assert property (@(posedge clk) disable iff (rst)
        rd_avail |-> img_ready);

    // R9: a read header raises the flag on the following cycle
    a_r9_flag_on_read_hdr: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_read) |=> img_ready);

    // R11: a header discards an untaken read word
    a_r11_hdr_drops_word: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> !rd_avail);
endmodule

// File: tb/vram_rect_xfer_bench.sv
`timescale 1ns/1ps
module vram_rect_xfer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic        hdr_read = 1'b0;
    logic [31:0] hdr_pos = '0;
    logic [31:0] hdr_size = '0;
    logic        wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic        wd_ready;
    logic        rd_take = 1'b0;
    logic [31:0] rd_data;
    logic        rd_avail;
    logic        img_ready;
    logic [18:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic        mem_re;
    logic [15:0] mem_rdata = '0;

    always #4 clk = ~clk;

    vram_rect_xfer u_vram_rect_xfer (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_read  (hdr_read),
        .hdr_pos   (hdr_pos),
        .hdr_size  (hdr_size),
        .wd_valid  (wd_valid),
        .wd_data   (wd_data),
        .wd_ready  (wd_ready),
        .rd_take   (rd_take),
        .rd_data   (rd_data),
        .rd_avail  (rd_avail),
        .img_ready (img_ready),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // frame memory model: sparse, with a computed background pattern
    logic [15:0] fb [int];

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 37 + 'h1234);
    endfunction

    function automatic logic [15:0] getpix(input int a);
        if (fb.exists(a)) return fb[a];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= getpix(int'(mem_addr));
        if (mem_we) fb[int'(mem_addr)] = mem_wdata;
    end

    // behavioural walk model
    int m_x0, m_row, m_w, m_rows, m_col;

    task automatic m_load(input int pos, input int size);
        m_x0   = pos & 1023;
        m_row  = (pos >> 16) & 511;
        m_w    = ((size & 1023) == 0) ? 1024 : (size & 1023);
        m_rows = (((size >> 16) & 511) == 0) ? 512 : ((size >> 16) & 511);
        m_col  = 0;
    endtask

    function automatic int m_addr();
        return m_row * 1024 + ((m_x0 + m_col) % 1024);
    endfunction

    task automatic m_step();
        if (m_col == m_w - 1) begin
            m_col  = 0;
            m_row  = (m_row + 1) % 512;
            m_rows = m_rows - 1;
        end else begin
            m_col = m_col + 1;
        end
    endtask

    // expected memory writes, compared on every clock
    int qa[$];
    int qd[$];

    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (mem_we && mem_re) chk(1'b0, "R12", "write and read together", 1, 0);
            if (mem_we) begin
                if (qa.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected write at", int'(mem_addr), -1);
                end else begin
                    int ea;
                    int ed;
                    ea = qa.pop_front();
                    ed = qd.pop_front();
                    chk(int'(mem_addr) == ea, cur_req, "write address", int'(mem_addr), ea);
                    chk(int'(mem_wdata) == ed, cur_req, "write data", int'(mem_wdata), ed);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // all tasks start and end on a falling edge
    task automatic header(input bit rd, input int pos, input int size);
        hdr_valid = 1'b1;
        hdr_read  = rd;
        hdr_pos   = pos;
        hdr_size  = size;
        qa.delete();
        qd.delete();
        m_load(pos, size);
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] d);
        wd_data  = d;
        wd_valid = 1'b1;
        while (!wd_ready) @(negedge clk);
        qa.push_back(m_addr());
        qd.push_back(int'(d[15:0]));
        m_step();
        if (m_rows > 0) begin
            qa.push_back(m_addr());
            qd.push_back(int'(d[31:16]));
            m_step();
        end
        @(negedge clk);
        wd_valid = 1'b0;
    endtask

    task automatic settle(input string req);
        repeat (4) @(negedge clk);
        chk(qa.size() == 0, req, "writes still missing", qa.size(), 0);
    endtask

    task automatic write_rect(input int pos, input int size, input int seed, input int gap);
        int n;
        header(1'b0, pos, size);
        n = m_w * m_rows;
        for (int i = 0; i < (n + 1) / 2; i++) begin
            send_word({16'(seed + 2 * i + 1), 16'(seed + 2 * i)});
            repeat (gap) @(negedge clk);
        end
        settle(cur_req);
    endtask

    task automatic take_word(input string req);
        logic [15:0] p0;
        logic [15:0] p1;
        while (!rd_avail) @(negedge clk);
        p0 = getpix(m_addr());
        m_step();
        if (m_rows > 0) begin
            p1 = getpix(m_addr());
            m_step();
        end else begin
            p1 = 16'h0;
        end
        chk(rd_data == {p1, p0}, req, "read word", int'(rd_data), int'({p1, p0}));
        rd_take = 1'b1;
        @(negedge clk);
        rd_take = 1'b0;
    endtask

    task automatic read_rect(input int pos, input int size, input string req);
        int n;
        header(1'b1, pos, size);
        chk(img_ready == 1'b1, "R9", "flag after read header", int'(img_ready), 1);
        n = m_w * m_rows;
        for (int i = 0; i < (n + 1) / 2; i++) take_word(req);
        chk(img_ready == 1'b0, "R9", "flag after last word", int'(img_ready), 0);
        repeat (4) @(negedge clk);
        chk(rd_avail == 1'b0, "R10", "no word after completion", int'(rd_avail), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(wd_ready == 1'b0, "R1", "wd_ready", int'(wd_ready), 0);
        chk(rd_avail == 1'b0, "R1", "rd_avail", int'(rd_avail), 0);
        chk(img_ready == 1'b0, "R1", "img_ready", int'(img_ready), 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R1", "memory strobes", int'({mem_we, mem_re}), 0);
        chk(rd_data == 32'h0, "R1", "rd_data", int'(rd_data), 0);

        // R2 R6: corner decode and pixel order, odd width spanning rows
        cur_req = "R2";
        write_rect(32'h000A_0005, 32'h0002_0003, 'h100, 0);

        // R7: odd total, upper half of final word dropped
        cur_req = "R7";
        write_rect(32'h0032_0028, 32'h0001_0003, 'h200, 0);
        chk(!fb.exists(50 * 1024 + 43), "R7", "pixel past rectangle written", 1, 0);

        // R4: column wraps at the right edge of the frame
        cur_req = "R4";
        write_rect(32'h0003_03FE, 32'h0001_0004, 'h300, 0);

        // R5: row wraps at the bottom of the frame
        cur_req = "R5";
        write_rect(32'h01FF_0000, 32'h0002_0002, 'h400, 1);

        // R8: idle gaps in the middle of rows
        cur_req = "R8";
        write_rect(32'h0046_003C, 32'h0002_0005, 'h500, 5);

        // R10: nothing accepted once finished
        cur_req = "R10";
        wd_valid = 1'b1;
        wd_data  = 32'hDEAD_BEEF;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(wd_ready == 1'b0, "R10", "ready after completion", int'(wd_ready), 0);
        end
        wd_valid = 1'b0;
        settle("R10");

        // R9 R12: read back with preload and one-cycle memory latency
        cur_req = "R9";
        read_rect(32'h000A_0005, 32'h0002_0003, "R9");
        read_rect(32'h0032_0028, 32'h0001_0003, "R7");
        read_rect(32'h01FF_0000, 32'h0002_0002, "R5");
        read_rect(32'h0003_03FE, 32'h0001_0004, "R4");

        // R11: write aborted by a new header
        cur_req = "R11";
        header(1'b0, 32'h0014_0064, 32'h0001_0004);
        send_word(32'hAAAA_5555);
        header(1'b0, 32'h001E_00C8, 32'h0001_0002);
        send_word(32'h7777_6666);
        settle("R11");
        chk(!fb.exists(20 * 1024 + 101), "R11", "aborted pixel written", 1, 0);
        chk(fb.exists(30 * 1024 + 201), "R11", "new rectangle second pixel", 0, 1);

        // R11: read aborted, pending word dropped
        header(1'b1, 32'h0028_012C, 32'h0004_0004);
        while (!rd_avail) @(negedge clk);
        header(1'b1, 32'h000A_0005, 32'h0002_0003);
        chk(rd_avail == 1'b0, "R11", "old word dropped", int'(rd_avail), 0);
        for (int i = 0; i < 3; i++) take_word("R11");
        chk(img_ready == 1'b0, "R11", "flag after new read", int'(img_ready), 0);

        // R3: zero width means 1024, zero height means 512
        cur_req = "R3";
        write_rect(32'h0064_0000, 32'h0001_0000, 'h1000, 0);
        chk(wd_ready == 1'b0, "R3", "ready after full row", int'(wd_ready), 0);
        write_rect(32'h0000_0007, 32'h0000_0001, 'h2000, 0);
        chk(wd_ready == 1'b0, "R3", "ready after full column", int'(wd_ready), 0);
        read_rect(32'h01FE_0007, 32'h0004_0001, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule